// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that moves data between a single peripheral and system memory, in either direction. It keeps two buffer slots. Each slot holds a current memory address and a remaining byte count. The channel drains the active slot one beat at a time. When that slot's count runs out, or when the peripheral marks a beat as the last one, the channel flags completion and switches to the other slot. Software can therefore refill one slot while the other is in use. If the other slot has not been loaded, the channel parks in a stalled state. It resumes on its own as soon as software writes a count into that slot.

The peripheral side is a request/acknowledge handshake. The request carries write data and an end-of-packet flag. The acknowledge carries read data. The memory side is a single-beat master with a request/ready pair and a byte/word size signal. A small register window gives software access to the control bits, the two slots and a status word. Apart from that register window, all channel state advances only while the enable bit is set.

Top module: `pdma_channel`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero, `irq` is low, and neither `mem_req` nor `per_ack` is asserted.
- R2: Writing a nonzero value to a slot's count register (select 3 for slot 0, 5 for slot 1) marks that slot valid (status bit 4 or 5). Writing zero leaves it invalid.
- R3: While control bit 0 (enable) is clear, `per_req` is ignored: no `per_ack` is given and no `mem_req` is issued. After re-enabling, a pending request is served.
- R4: Each accepted request yields exactly one single-cycle `per_ack`. When control bit 1 is clear (memory to peripheral), `per_rdata` carries the word read from the active address. In byte mode only the low 8 bits are kept and the rest are zero.
- R5: When control bit 1 is set (peripheral to memory), the channel issues a write with `mem_we` high to the active address. The data is `per_wdata`, cut to its low 8 bits in byte mode. `mem_word` always follows control bit 2.
- R6: After each beat, the active slot's address grows by 1 in byte mode or by 4 in word mode (control bit 2). Its count shrinks by the same amount and stops at zero.
- R7: When a slot's count reaches zero, that slot becomes invalid, its done flag is set (status bit 0 or 1), and its full flag is set (status bit 2 or 3).
- R8: A beat with `per_last` high ends the slot early. The done flag is set, the full flag reads zero, and the count register keeps the untransferred remainder.
- R9: On completion the active slot (status bit 6) flips to the other slot. If that slot is valid, the next request is served from its address with no software action.
- R10: If the other slot is invalid at completion, stalled (status bit 7) is set and requests are ignored. Once software loads the now-active slot, stalled clears and the transfer continues at that slot's address.
- R11: `irq` is high exactly when control bit 3 is set and at least one done flag is set. Writing 1 to status bit 0 or 1 clears that done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 status, 2/3 slot 0 address/count, 4/5 slot 1 address/count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Completion interrupt |
| per_req | input | 1 | Peripheral transfer request |
| per_last | input | 1 | Marks the requested beat as the last of the buffer |
| per_wdata | input | 32 | Data from the peripheral |
| per_ack | output | 1 | One-cycle acknowledge for an accepted request |
| per_rdata | output | 32 | Data to the peripheral, valid with `per_ack` |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_word | output | 1 | 1 for a 4-byte beat, 0 for a byte beat |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory beat completes this cycle |

## Verification
The assertions rely on three assumptions about the inputs. The peripheral keeps `per_req` and its data steady until it sees `per_ack` and drops the request in the next cycle. Memory returns `mem_ready` only while `mem_req` is high. Software leaves direction and width alone while a beat is in flight. The bench's peripheral task lowers the request at the first sampling point where the acknowledge is seen. Its memory model raises ready for one cycle, one half-cycle after it sees a request. Control bits are only rewritten between beats. Each direction and width is swept against arithmetically predicted addresses, counts, data and status words.

// File: rtl/pdma_pkg.sv
// Package: shared constants and types of the ping-pong peripheral DMA channel.
// Assumes a 32-bit register and data path; address and count widths are
// parameters of the modules that use them.
package pdma_pkg;

    localparam int DATA_W = 32;

    // register window selects
    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_STAT = 3'd1;
    localparam logic [2:0] SEL_A0   = 3'd2;
    localparam logic [2:0] SEL_C0   = 3'd3;
    localparam logic [2:0] SEL_A1   = 3'd4;
    localparam logic [2:0] SEL_C1   = 3'd5;

    // beat engine states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_ACK  = 2'd2
    } pdma_state_e;

endpackage

// File: rtl/pdma_slot.sv
// Module: one buffer slot (current address, remaining count, flags).
// Software writes take priority over hardware advancement in the same cycle.
// A nonzero count write makes the slot valid; completion clears it.
module pdma_slot #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic [ADDR_W-1:0] wr_addr_val,
    input  logic [CNT_W-1:0]  wr_cnt_val,
    input  logic              adv,
    input  logic              fin,
    input  logic [CNT_W-1:0]  step,
    input  logic              clr_done,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cnt,
    output logic              valid,
    output logic              done,
    output logic              full
);

    logic [CNT_W-1:0] cnt_nxt;

    // remaining count after one beat, floored at zero
    always_comb begin
        cnt_nxt = (cnt <= step) ? '0 : cnt - step;
    end

    // address register: software load or per-beat increment
    always_ff @(posedge clk) begin
        if (!rst_n)       addr <= '0;
        else if (wr_addr) addr <= wr_addr_val;
        else if (adv)     addr <= addr + ADDR_W'(step);
    end

    // count and valid: software load arms, completion disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            valid <= 1'b0;
        end else if (wr_cnt) begin
            cnt   <= wr_cnt_val;
            valid <= |wr_cnt_val;
        end else if (adv) begin
            cnt <= cnt_nxt;
            if (fin) valid <= 1'b0;
        end
    end

    // completion flags: done is sticky until cleared, full records exhaustion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            full <= 1'b0;
        end else if (adv && fin) begin
            done <= 1'b1;
            full <= (cnt_nxt == '0);
        end else if (clr_done) begin
            done <= 1'b0;
        end
    end

endmodule

// File: rtl/pdma_engine.sv
// Module: beat engine. Accepts one peripheral request at a time, performs one
// memory beat, then acknowledges. All state is clock-enabled by `en`.
// Assumes the peripheral holds its request until acknowledged and drops it
// the cycle after, and that dir/word stay still while a beat is in flight.
module pdma_engine #(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      dir,
    input  logic                      word,
    input  logic                      act_valid,
    input  logic [CNT_W-1:0]          act_cnt,
    input  logic                      per_req,
    input  logic                      per_last,
    input  logic [pdma_pkg::DATA_W-1:0] per_wdata,
    output logic                      per_ack,
    output logic [pdma_pkg::DATA_W-1:0] per_rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic                      mem_word,
    output logic [pdma_pkg::DATA_W-1:0] mem_wdata,
    input  logic [pdma_pkg::DATA_W-1:0] mem_rdata,
    input  logic                      mem_ready,
    output logic [CNT_W-1:0]          step,
    output logic                      beat,
    output logic                      beat_fin
);
    import pdma_pkg::*;

    pdma_state_e          state_q;
    logic [DATA_W-1:0]    buf_q;
    logic                 last_q;
    logic [DATA_W-1:0]    per_cut;
    logic [DATA_W-1:0]    mem_cut;

    // width reduction of both data sources for byte mode
    always_comb begin
        per_cut = word ? per_wdata : {{(DATA_W-8){1'b0}}, per_wdata[7:0]};
        mem_cut = word ? mem_rdata : {{(DATA_W-8){1'b0}}, mem_rdata[7:0]};
        step    = word ? CNT_W'(4) : CNT_W'(1);
    end

    // beat sequencer: idle -> memory beat -> acknowledge, frozen when disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            buf_q   <= '0;
            last_q  <= 1'b0;
        end else if (en) begin
            case (state_q)
                ST_IDLE: if (act_valid && per_req) begin
                    if (dir) buf_q <= per_cut;
                    last_q  <= per_last;
                    state_q <= ST_XFER;
                end
                ST_XFER: if (mem_ready) begin
                    if (!dir) buf_q <= mem_cut;
                    state_q <= ST_ACK;
                end
                ST_ACK:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // bus and handshake outputs, gated by the channel enable
    always_comb begin
        mem_req   = en && (state_q == ST_XFER);
        mem_we    = dir;
        mem_word  = word;
        mem_wdata = buf_q;
        per_ack   = en && (state_q == ST_ACK);
        per_rdata = buf_q;
        beat      = per_ack;
        beat_fin  = beat && (last_q || (act_cnt <= step));
    end

endmodule

// File: rtl/pdma_regs.sv
// Module: register window, control bits, active-slot pointer, stall flag and
// interrupt. Write strobes to the slots are decoded here; status done bits
// are write-1-to-clear. Reads are combinational on the select.
module pdma_regs #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [2:0]                    reg_sel,
    input  logic [pdma_pkg::DATA_W-1:0]   reg_wdata,
    output logic [pdma_pkg::DATA_W-1:0]   reg_rdata,
    output logic                          en,
    output logic                          dir,
    output logic                          word,
    output logic                          irq_en,
    output logic                          active,
    output logic                          stalled,
    output logic                          irq,
    output logic [1:0]                    wr_addr,
    output logic [1:0]                    wr_cnt,
    output logic [ADDR_W-1:0]             wr_addr_val,
    output logic [CNT_W-1:0]              wr_cnt_val,
    output logic [1:0]                    clr_done,
    input  logic [1:0][ADDR_W-1:0]        slot_addr,
    input  logic [1:0][CNT_W-1:0]         slot_cnt,
    input  logic [1:0]                    slot_valid,
    input  logic [1:0]                    slot_done,
    input  logic [1:0]                    slot_full,
    input  logic                          beat_fin
);
    import pdma_pkg::*;

    logic other;

    // write decode toward the slots and the done-flag clear
    always_comb begin
        wr_addr[0]  = reg_wr && (reg_sel == SEL_A0);
        wr_addr[1]  = reg_wr && (reg_sel == SEL_A1);
        wr_cnt[0]   = reg_wr && (reg_sel == SEL_C0);
        wr_cnt[1]   = reg_wr && (reg_sel == SEL_C1);
        wr_addr_val = reg_wdata[ADDR_W-1:0];
        wr_cnt_val  = reg_wdata[CNT_W-1:0];
        clr_done    = (reg_wr && (reg_sel == SEL_STAT)) ? reg_wdata[1:0] : 2'b00;
        other       = ~active;
    end

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            dir    <= 1'b0;
            word   <= 1'b0;
            irq_en <= 1'b0;
        end else if (reg_wr && (reg_sel == SEL_CTRL)) begin
            en     <= reg_wdata[0];
            dir    <= reg_wdata[1];
            word   <= reg_wdata[2];
            irq_en <= reg_wdata[3];
        end
    end

    // slot pointer flips on completion; stall if the next slot is empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            stalled <= 1'b0;
        end else if (beat_fin) begin
            active  <= other;
            stalled <= !slot_valid[other];
        end else if (stalled && slot_valid[active]) begin
            stalled <= 1'b0;
        end
    end

    // interrupt from any done flag under the mask
    always_comb begin
        irq = irq_en && (|slot_done);
    end

    // read multiplexer
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {{(DATA_W-4){1'b0}}, irq_en, word, dir, en};
            SEL_STAT: reg_rdata = {{(DATA_W-8){1'b0}}, stalled, active,
                                   slot_valid, slot_full, slot_done};
            SEL_A0:   reg_rdata = DATA_W'(slot_addr[0]);
            SEL_C0:   reg_rdata = DATA_W'(slot_cnt[0]);
            SEL_A1:   reg_rdata = DATA_W'(slot_addr[1]);
            SEL_C1:   reg_rdata = DATA_W'(slot_cnt[1]);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pdma_channel.sv
// Module: top of the ping-pong peripheral DMA channel. Ties the register
// window, two buffer slots and the beat engine together; the active slot
// supplies the memory address and the count used for completion.
module pdma_channel #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic              per_req,
    input  logic              per_last,
    input  logic [31:0]       per_wdata,
    output logic              per_ack,
    output logic [31:0]       per_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready
);

    localparam int NSLOT = 2;

    logic                          chan_en, chan_dir, chan_word, chan_irq_en;
    logic                          chan_active, chan_stalled;
    logic [NSLOT-1:0]              wr_addr, wr_cnt, clr_done;
    logic [ADDR_W-1:0]             wr_addr_val;
    logic [CNT_W-1:0]              wr_cnt_val;
    logic [NSLOT-1:0][ADDR_W-1:0]  slot_addr;
    logic [NSLOT-1:0][CNT_W-1:0]   slot_cnt;
    logic [NSLOT-1:0]              slot_valid, slot_done, slot_full;
    logic [CNT_W-1:0]              step;
    logic                          beat, beat_fin;

    pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .en(chan_en), .dir(chan_dir), .word(chan_word), .irq_en(chan_irq_en),
        .active(chan_active), .stalled(chan_stalled), .irq(irq),
        .wr_addr(wr_addr), .wr_cnt(wr_cnt),
        .wr_addr_val(wr_addr_val), .wr_cnt_val(wr_cnt_val),
        .clr_done(clr_done),
        .slot_addr(slot_addr), .slot_cnt(slot_cnt), .slot_valid(slot_valid),
        .slot_done(slot_done), .slot_full(slot_full),
        .beat_fin(beat_fin)
    );

    // one slot instance per buffer; only the active one advances
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic is_act;
        assign is_act = (chan_active == 1'(i));
        pdma_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_addr(wr_addr[i]), .wr_cnt(wr_cnt[i]),
            .wr_addr_val(wr_addr_val), .wr_cnt_val(wr_cnt_val),
            .adv(beat && is_act), .fin(beat_fin), .step(step),
            .clr_done(clr_done[i]),
            .addr(slot_addr[i]), .cnt(slot_cnt[i]), .valid(slot_valid[i]),
            .done(slot_done[i]), .full(slot_full[i])
        );
    end

    pdma_engine #(.CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .en(chan_en), .dir(chan_dir), .word(chan_word),
        .act_valid(slot_valid[chan_active]), .act_cnt(slot_cnt[chan_active]),
        .per_req(per_req), .per_last(per_last), .per_wdata(per_wdata),
        .per_ack(per_ack), .per_rdata(per_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .step(step), .beat(beat), .beat_fin(beat_fin)
    );

    assign mem_addr = slot_addr[chan_active];

endmodule

// File: rtl/pdma_channel_chk.sv
// Module: assertion checker bound into pdma_channel. Assumes memory raises
// ready only while a request is outstanding.
module pdma_channel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              per_ack,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              chan_en,
    input logic              chan_stalled
);

    // R4
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);

    // R3
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> (!mem_req && !per_ack));

    // R4
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (!chan_en || (mem_req && $stable(mem_addr))));

    // R4
    ack_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && chan_en) |=> (per_ack || !chan_en));

    // R10
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_stalled |-> !mem_req);

endmodule

bind pdma_channel pdma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .per_ack(per_ack), .mem_req(mem_req),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .chan_en(chan_en),
    .chan_stalled(chan_stalled)
);

// File: tb/pdma_channel_bench.sv
module pdma_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq, per_req = 1'b0, per_last = 1'b0, per_ack;
    logic [31:0] per_wdata = '0, per_rdata;
    logic mem_req, mem_we, mem_word, mem_ready = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;

    int checks = 0, fails = 0, acks = 0, log_n = 0;
    logic [31:0] log_addr [0:255];
    logic        log_we   [0:255];
    logic        log_word [0:255];
    logic [31:0] log_wd   [0:255];

    pdma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pdma_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .per_req(per_req), .per_last(per_last), .per_wdata(per_wdata),
        .per_ack(per_ack), .per_rdata(per_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h0101_0107) ^ 32'h3C5A_96E1;
    endfunction

    function automatic logic [31:0] cut(input logic [31:0] d, input logic w);
        return w ? d : {24'b0, d[7:0]};
    endfunction

    // memory model and acknowledge counter
    always @(negedge clk) begin
        if (per_ack) acks++;
        if (mem_req && !mem_ready) begin
            if (log_n < 256) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_we;
                log_word[log_n] = mem_word;
                log_wd[log_n]   = mem_wdata;
                log_n++;
            end
            mem_rdata = pat(mem_addr);
            mem_ready = 1'b1;
        end else begin
            mem_ready = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic do_beat(input logic last, input logic [31:0] wd,
                           output logic [31:0] rd, output logic ok);
        int t;
        @(negedge clk);
        per_req = 1'b1; per_last = last; per_wdata = wd;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!per_ack && t < 50);
        ok = per_ack;
        rd = per_rdata;
        per_req = 1'b0; per_last = 1'b0;
        #1;
    endtask

    task automatic quiet_window(input string tag);
        int seen;
        seen = 0;
        @(negedge clk);
        per_req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (per_ack || mem_req) seen++;
        end
        per_req = 1'b0;
        chk(tag, 32'(seen), 32'd0);
    endtask

    task automatic run_case(input logic dir, input logic wd);
        logic [31:0] v, rd, a0, a1, base, wdv, cbase, stp, c0, c1;
        logic ok;
        int n0, n1, nb, ab, lb;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        stp = wd ? 32'd4 : 32'd1;
        c0  = wd ? 32'd10 : 32'd5;
        c1  = wd ? 32'd8 : 32'd3;
        a0  = 32'h1000 + (dir ? 32'h400 : 32'h0) + (wd ? 32'h200 : 32'h0);
        a1  = a0 + 32'h100;
        n0  = int'((c0 + stp - 1) / stp);
        n1  = int'((c1 + stp - 1) / stp);
        wr_reg(3'd0, {28'b0, 1'b1, wd, dir, 1'b1});
        wr_reg(3'd2, a0); wr_reg(3'd3, c0);
        wr_reg(3'd4, a1); wr_reg(3'd5, c1);
        rd_reg(3'd1, v);
        chk("R2 both slots valid", v, 32'h30);
        for (int d = 0; d < 2; d++) begin
            nb = (d == 0) ? n0 : n1;
            base = (d == 0) ? a0 : a1;
            cbase = (d == 0) ? c0 : c1;
            for (int i = 0; i < nb; i++) begin
                ab = acks; lb = log_n;
                wdv = 32'hC0DE_0000 + 32'(d * 256 + i * 19) + (dir ? 32'h77 : 32'h0);
                do_beat(1'b0, wdv, rd, ok);
                chk("R4 one ack per request", 32'(acks - ab), 32'd1);
                chk("R6 beat address", log_addr[lb], base + 32'(i) * stp);
                chk("R5 write enable follows direction", 32'(log_we[lb]), 32'(dir));
                chk("R5 size follows width", 32'(log_word[lb]), 32'(wd));
                if (dir) chk("R5 write data", log_wd[lb], cut(wdv, wd));
                else     chk("R4 read data to peripheral", rd, cut(pat(base + 32'(i) * stp), wd));
                if (i == 0) begin
                    rd_reg((d == 0) ? 3'd3 : 3'd5, v);
                    chk("R6 count after first beat", v, cbase - stp);
                    rd_reg((d == 0) ? 3'd2 : 3'd4, v);
                    chk("R6 address after first beat", v, base + stp);
                end
            end
            rd_reg(3'd1, v);
            if (d == 0) begin
                chk("R7 R9 status after slot 0", v, 32'h65);
                chk("R11 irq raised", 32'(irq), 32'd1);
            end else begin
                chk("R10 stalled after slot 1", v, 32'h8F);
                rd_reg(3'd4, v);
                chk("R6 final address slot 1", v, a1 + 32'(n1) * stp);
                rd_reg(3'd5, v);
                chk("R6 count floors at zero", v, 32'd0);
            end
        end
        quiet_window("R10 requests ignored while stalled");
        wr_reg(3'd3, stp);
        rd_reg(3'd1, v);
        chk("R10 stall released by load", v, 32'h1F);
        lb = log_n;
        do_beat(1'b0, 32'h1234_5678, rd, ok);
        chk("R10 resumes at slot 0 address", log_addr[lb], a0 + 32'(n0) * stp);
        wr_reg(3'd0, {28'b0, 1'b0, wd, dir, 1'b1});
        rd_reg(3'd1, v);
        chk("R11 irq masked", 32'(irq), 32'd0);
        wr_reg(3'd0, {28'b0, 1'b1, wd, dir, 1'b1});
        rd_reg(3'd1, v);
        chk("R11 irq unmasked", 32'(irq), 32'd1);
        wr_reg(3'd1, 32'h3);
        rd_reg(3'd1, v);
        chk("R11 done cleared", v & 32'h3, 32'd0);
        chk("R11 irq low after clear", 32'(irq), 32'd0);
        wr_reg(3'd5, 4 * stp);
        lb = log_n;
        do_beat(1'b1, 32'hFACE_0001, rd, ok);
        chk("R8 early end address", log_addr[lb], a1 + 32'(n1) * stp);
        rd_reg(3'd1, v);
        chk("R8 done1 set full1 clear", v & 32'hA, 32'h2);
        rd_reg(3'd5, v);
        chk("R8 remainder kept", v, 3 * stp);
        wr_reg(3'd0, {28'b0, 1'b1, wd, dir, 1'b0});
        wr_reg(3'd3, stp);
        quiet_window("R3 requests ignored while disabled");
        wr_reg(3'd0, {28'b0, 1'b1, wd, dir, 1'b1});
        ab = acks; lb = log_n;
        do_beat(1'b0, 32'h0BAD_F00D, rd, ok);
        chk("R3 served after enable", 32'(acks - ab), 32'd1);
        chk("R3 address after enable", log_addr[lb], a0 + 32'(n0 + 1) * stp);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
        chk("R1 per_ack after reset", 32'(per_ack), 32'd0);
        for (int s = 0; s < 6; s++) begin
            rd_reg(3'(s), v);
            chk("R1 register after reset", v, 32'd0);
        end
        for (int dir = 0; dir < 2; dir++)
            for (int wd = 0; wd < 2; wd++)
                run_case(1'(dir), 1'(wd));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule